// File: doc/BRIEF.md
# External Interrupt Priority Selector

This block keeps the pending external interrupt conditions of one processor and, on each evaluation request made while the processor accepts external interrupts, serves exactly one of them. Eight classes compete under a fixed order. Two classes, malfunction alert and emergency signal, keep a bitmap of sending processors. Two others, clock comparator and CPU timer, are conditions computed afresh from live inputs and are never stored. Each class can be switched off by its own mask bit. A masked class is passed over and its pending state is kept.

The winner is announced by a one-cycle valid pulse that carries the interrupt code, the originating processor address and a parameter word. After the pulse, a short run of write strobes fills the low-memory save area, one field per cycle. Only the condition that was served is cleared. Everything else stays pending for later evaluations.

The controller has five states. ST_IDLE waits for a request. ST_POST presents the result. ST_WR_PARM writes the parameter word (service signal only). ST_WR_CPU writes the processor-address halfword. ST_WR_CODE writes the code halfword. The transitions are:
- accept: ST_IDLE to ST_POST, on an enabled request that finds a servable class;
- post-to-parm: ST_POST to ST_WR_PARM, for a service signal;
- post-to-cpu: ST_POST to ST_WR_CPU, for every other class;
- parm-to-cpu: ST_WR_PARM to ST_WR_CPU;
- cpu-to-code: ST_WR_CPU to ST_WR_CODE;
- done: ST_WR_CODE to ST_IDLE.

Top module: `ext_irq_selector`

## Requirements
- R1: An evaluation serves at most one class. The class is the first requesting class in this order, and class_mask uses the same index: bit 0 interrupt key, 1 malfunction alert, 2 emergency signal, 3 external call, 4 clock comparator, 5 CPU timer, 6 interval timer, 7 service signal.
- R2: A class whose class_mask bit is 0 is skipped, and its pending state is unchanged.
- R3: A malfunction alert or emergency signal serves the lowest-numbered set sender bit and clears only that bit. The class flag stays set while higher-numbered senders remain.
- R4: If a malfunction-alert or emergency-signal flag wins while its sender bitmap is empty, the flag is cleared and no interrupt is produced on that evaluation.
- R5: irq_cpu carries the sender address for malfunction alert, emergency signal and external call, and zero otherwise. The halfword written at save offset 0x084 is the sender address for emergency signal and external call only, and zero for all other classes, malfunction alert included.
- R6: The clock-comparator condition is tod strictly greater than clk_cmp. The CPU-timer condition is the most significant bit of cpu_timer being 1. Neither is stored, so a served condition that stays true is served again.
- R7: A service signal presents its parameter on irq_parm and writes it as a word at offset 0x080, then clears both the parameter and its pending bit. When parameter bit 0 is set, prefix relocation is applied first: page 0 moves to the prefix page, the prefix page moves to page 0, and other pages are unchanged.
- R8: The code halfword is written at offset 0x084+2 = 0x086 and is the last strobe. The codes are key 0x0040, malfunction 0x1200, emergency 0x1201, external call 0x1202, comparator 0x1004, CPU timer 0x1005, interval timer 0x0080, service 0x2401.
- R9: irq_valid is high for exactly one cycle, the cycle after the clock edge that samples the request. Strobes follow, one per cycle, in this order: 0x080 (service signal only), 0x084, 0x086.
- R10: A request is ignored while ext_enable is 0, and also while a previous result is still being posted or written.
- R11: A raise input that arrives on the same edge that serves that source leaves the source pending.
- R12: After reset nothing is pending, and no pulse or strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_enable | input | 1 | Processor accepts external interrupts |
| eval_req | input | 1 | Request one evaluation |
| class_mask | input | 8 | Per-class enable, index as in R1 |
| raise_key | input | 1 | Set interrupt-key pending |
| raise_malf | input | 1 | Set malfunction-alert flag and OR in malf_from |
| malf_from | input | NCPU | Malfunction-alert senders |
| raise_emer | input | 1 | Set emergency-signal flag and OR in emer_from |
| emer_from | input | NCPU | Emergency-signal senders |
| raise_xcall | input | 1 | Set external-call pending and load xcall_from |
| xcall_from | input | AW | External-call sender address |
| raise_itmr | input | 1 | Set interval-timer pending |
| raise_svc | input | 1 | Set service-signal pending and load svc_parm_in |
| svc_parm_in | input | PW | Service-signal parameter |
| tod | input | TW | Time-of-day value |
| clk_cmp | input | TW | Clock comparator |
| cpu_timer | input | TW | Signed CPU timer |
| prefix | input | PW | Prefix register |
| irq_valid | output | 1 | One-cycle result pulse |
| irq_code | output | 16 | Interrupt code |
| irq_cpu | output | AW | Originating processor address |
| irq_parm | output | PW | Parameter word |
| sa_we | output | 1 | Save-area write strobe |
| sa_word | output | 1 | 1 for a word write, 0 for a halfword write |
| sa_addr | output | SAW | Save-area byte offset |
| sa_data | output | PW | Write data, right-aligned |

## Verification
A serve and a raise of the same source can land on the same clock edge. The bench asserts raise_key together with an evaluation that serves the key. It then expects a second evaluation to serve the key again and a third to find nothing. An evaluation request can also arrive while the sequencer is still posting. The bench re-requests during the pulse cycle and judges the outcome at the ports: the normal strobe run must follow undisturbed, and the next real evaluation must serve the source that was left pending.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int NUM_CLS = 8;

    typedef enum logic [2:0] {
        CLS_KEY    = 3'd0,
        CLS_MALF   = 3'd1,
        CLS_EMER   = 3'd2,
        CLS_XCALL  = 3'd3,
        CLS_CLKC   = 3'd4,
        CLS_CPUTMR = 3'd5,
        CLS_ITMR   = 3'd6,
        CLS_SVC    = 3'd7
    } ext_cls_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POST,
        ST_WR_PARM,
        ST_WR_CPU,
        ST_WR_CODE
    } seq_state_e;

    localparam logic [11:0] SA_PARM = 12'h080;
    localparam logic [11:0] SA_CPU  = 12'h084;
    localparam logic [11:0] SA_CODE = 12'h086;

    function automatic logic [15:0] cls_code(ext_cls_e c);
        logic [15:0] r;
        unique case (c)
            CLS_KEY:    r = 16'h0040;
            CLS_MALF:   r = 16'h1200;
            CLS_EMER:   r = 16'h1201;
            CLS_XCALL:  r = 16'h1202;
            CLS_CLKC:   r = 16'h1004;
            CLS_CPUTMR: r = 16'h1005;
            CLS_ITMR:   r = 16'h0080;
            CLS_SVC:    r = 16'h2401;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ext_irq_lowscan.sv
module ext_irq_lowscan #(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  first
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_chain
        assign first[g]  = vec[g] & ~seen[g];
        assign seen[g+1] = seen[g] | vec[g];
    end

    assign found = seen[N];

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (first[i]) idx = idx | IW'(i);
        end
    end
endmodule

// File: rtl/ext_irq_relocate.sv
module ext_irq_relocate #(
    parameter int W    = 32,
    parameter int PG   = 12,
    parameter int FLAG = 0
) (
    input  logic [W-1:0] parm,
    input  logic [W-1:0] prefix,
    output logic [W-1:0] out
);
    localparam int HW = W - PG;

    logic [HW-1:0] page, pfx_page;
    assign page     = parm[W-1:PG];
    assign pfx_page = prefix[W-1:PG];

    always_comb begin
        out = parm;
        if (parm[FLAG]) begin
            if (page == '0)
                out = {pfx_page, parm[PG-1:0]};
            else if (page == pfx_page)
                out = {{HW{1'b0}}, parm[PG-1:0]};
        end
    end
endmodule

// File: rtl/ext_irq_selector.sv
module ext_irq_selector
    import ext_irq_pkg::*;
#(
    parameter int NCPU = 8,
    parameter int AW   = 16,
    parameter int TW   = 64,
    parameter int PW   = 32,
    parameter int SAW  = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_enable,
    input  logic            eval_req,
    input  logic [7:0]      class_mask,
    input  logic            raise_key,
    input  logic            raise_malf,
    input  logic [NCPU-1:0] malf_from,
    input  logic            raise_emer,
    input  logic [NCPU-1:0] emer_from,
    input  logic            raise_xcall,
    input  logic [AW-1:0]   xcall_from,
    input  logic            raise_itmr,
    input  logic            raise_svc,
    input  logic [PW-1:0]   svc_parm_in,
    input  logic [TW-1:0]   tod,
    input  logic [TW-1:0]   clk_cmp,
    input  logic [TW-1:0]   cpu_timer,
    input  logic [PW-1:0]   prefix,
    output logic            irq_valid,
    output logic [15:0]     irq_code,
    output logic [AW-1:0]   irq_cpu,
    output logic [PW-1:0]   irq_parm,
    output logic            sa_we,
    output logic            sa_word,
    output logic [SAW-1:0]  sa_addr,
    output logic [PW-1:0]   sa_data
);
    localparam int CIW = (NCPU > 1) ? $clog2(NCPU) : 1;

    // pending state
    logic            key_p, malf_f, emer_f, xcall_p, itmr_p, svc_p;
    logic [NCPU-1:0] malf_bm, emer_bm;
    logic [AW-1:0]   xcall_src;
    logic [PW-1:0]   svc_parm;

    // latched result
    ext_cls_e      win_cls;
    logic [15:0]   win_code;
    logic [AW-1:0] win_cpu, win_save_cpu;
    logic [PW-1:0] win_parm;

    seq_state_e state, state_nx;

    // class pick
    logic [NUM_CLS-1:0] cls_req, pick_1h, clr;
    logic [2:0]         pick_idx;
    logic               any_req;
    ext_cls_e           pick;

    assign cls_req = class_mask & {svc_p, itmr_p, cpu_timer[TW-1], (tod > clk_cmp),
                                   xcall_p, emer_f, malf_f, key_p};

    ext_irq_lowscan #(.N(NUM_CLS), .IW(3)) u_pick (
        .vec(cls_req), .found(any_req), .idx(pick_idx), .first(pick_1h));

    assign pick = ext_cls_e'(pick_idx);

    // sender scans
    logic            malf_any, emer_any;
    logic [CIW-1:0]  malf_idx, emer_idx;
    logic [NCPU-1:0] malf_first, emer_first;

    ext_irq_lowscan #(.N(NCPU), .IW(CIW)) u_malf_scan (
        .vec(malf_bm), .found(malf_any), .idx(malf_idx), .first(malf_first));
    ext_irq_lowscan #(.N(NCPU), .IW(CIW)) u_emer_scan (
        .vec(emer_bm), .found(emer_any), .idx(emer_idx), .first(emer_first));

    logic [PW-1:0] svc_reloc;
    ext_irq_relocate #(.W(PW), .PG(12), .FLAG(0)) u_reloc (
        .parm(svc_parm), .prefix(prefix), .out(svc_reloc));

    logic go, empty_hit, fire;
    assign go        = (state == ST_IDLE) && eval_req && ext_enable && any_req;
    assign empty_hit = ((pick == CLS_MALF) && !malf_any) || ((pick == CLS_EMER) && !emer_any);
    assign fire      = go && !empty_hit;
    assign clr       = go ? pick_1h : '0;

    logic [AW-1:0] sel_cpu, sel_save;
    always_comb begin
        sel_cpu = '0;
        unique case (pick)
            CLS_MALF:  sel_cpu = AW'(malf_idx);
            CLS_EMER:  sel_cpu = AW'(emer_idx);
            CLS_XCALL: sel_cpu = xcall_src;
            default:   sel_cpu = '0;
        endcase
        sel_save = ((pick == CLS_EMER) || (pick == CLS_XCALL)) ? sel_cpu : '0;
    end

    // pending bookkeeping: raise wins over a same-edge clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_p <= 1'b0; malf_f <= 1'b0; emer_f <= 1'b0;
            xcall_p <= 1'b0; itmr_p <= 1'b0; svc_p <= 1'b0;
            malf_bm <= '0; emer_bm <= '0; xcall_src <= '0; svc_parm <= '0;
        end else begin
            key_p   <= (key_p  & ~clr[CLS_KEY])  | raise_key;
            itmr_p  <= (itmr_p & ~clr[CLS_ITMR]) | raise_itmr;
            xcall_p <= (xcall_p & ~clr[CLS_XCALL]) | raise_xcall;
            if (raise_xcall) xcall_src <= xcall_from;
            malf_bm <= (malf_bm & ~(clr[CLS_MALF] ? malf_first : '0))
                     | (raise_malf ? malf_from : '0);
            malf_f  <= (clr[CLS_MALF] ? |(malf_bm & ~malf_first) : malf_f) | raise_malf;
            emer_bm <= (emer_bm & ~(clr[CLS_EMER] ? emer_first : '0))
                     | (raise_emer ? emer_from : '0);
            emer_f  <= (clr[CLS_EMER] ? |(emer_bm & ~emer_first) : emer_f) | raise_emer;
            svc_p   <= (svc_p & ~clr[CLS_SVC]) | raise_svc;
            if (raise_svc)         svc_parm <= svc_parm_in;
            else if (clr[CLS_SVC]) svc_parm <= '0;
        end
    end

    // result latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cls <= CLS_KEY; win_code <= '0; win_cpu <= '0;
            win_save_cpu <= '0; win_parm <= '0;
        end else if (fire) begin
            win_cls      <= pick;
            win_code     <= cls_code(pick);
            win_cpu      <= sel_cpu;
            win_save_cpu <= sel_save;
            win_parm     <= (pick == CLS_SVC) ? svc_reloc : '0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (fire) state_nx = ST_POST;
            ST_POST:    state_nx = (win_cls == CLS_SVC) ? ST_WR_PARM : ST_WR_CPU;
            ST_WR_PARM: state_nx = ST_WR_CPU;
            ST_WR_CPU:  state_nx = ST_WR_CODE;
            ST_WR_CODE: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        irq_valid = 1'b0; irq_code = '0; irq_cpu = '0; irq_parm = '0;
        sa_we = 1'b0; sa_word = 1'b0; sa_addr = '0; sa_data = '0;
        unique case (state)
            ST_IDLE: ;
            ST_POST: begin
                irq_valid = 1'b1;
                irq_code  = win_code;
                irq_cpu   = win_cpu;
                irq_parm  = win_parm;
            end
            ST_WR_PARM: begin
                sa_we = 1'b1; sa_word = 1'b1;
                sa_addr = SAW'(SA_PARM); sa_data = win_parm;
            end
            ST_WR_CPU: begin
                sa_we = 1'b1;
                sa_addr = SAW'(SA_CPU); sa_data = PW'(win_save_cpu);
            end
            ST_WR_CODE: begin
                sa_we = 1'b1;
                sa_addr = SAW'(SA_CODE); sa_data = PW'(win_code);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ext_irq_selector_chk.sv
module ext_irq_selector_chk
    import ext_irq_pkg::*;
#(
    parameter int TW  = 64,
    parameter int SAW = 12
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ext_enable,
    input logic           eval_req,
    input seq_state_e     state,
    input logic           irq_valid,
    input logic [15:0]    irq_code,
    input logic           sa_we,
    input logic           sa_word,
    input logic [SAW-1:0] sa_addr,
    input logic [TW-1:0]  tod,
    input logic [TW-1:0]  clk_cmp,
    input logic [TW-1:0]  cpu_timer
);
    assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> !irq_valid);

    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_valid && sa_we));

    assert_post_then_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> sa_we);

    assert_code_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sa_we && sa_addr == SAW'(SA_CODE)) |=> !sa_we);

    assert_cpu_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sa_we && sa_addr == SAW'(SA_CPU)) |-> !sa_word);

    assert_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && eval_req && !ext_enable) |=> !irq_valid);

    assert_clkc_strict_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_code == 16'h1004) |-> $past(tod > clk_cmp));

    assert_timer_neg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_code == 16'h1005) |-> $past(cpu_timer[TW-1]));
endmodule

bind ext_irq_selector ext_irq_selector_chk #(.TW(TW), .SAW(SAW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ext_enable(ext_enable), .eval_req(eval_req),
    .state(state), .irq_valid(irq_valid), .irq_code(irq_code), .sa_we(sa_we),
    .sa_word(sa_word), .sa_addr(sa_addr), .tod(tod), .clk_cmp(clk_cmp),
    .cpu_timer(cpu_timer));

// File: tb/ext_irq_selector_tb.sv
`timescale 1ns/1ps
module ext_irq_selector_tb;
    localparam int NCPU = 8, AW = 16, TW = 64, PW = 32, SAW = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ext_enable = 1'b1, eval_req = 1'b0;
    logic [7:0] class_mask = 8'hFF;
    logic raise_key = 0, raise_malf = 0, raise_emer = 0, raise_xcall = 0;
    logic raise_itmr = 0, raise_svc = 0;
    logic [NCPU-1:0] malf_from = '0, emer_from = '0;
    logic [AW-1:0] xcall_from = '0;
    logic [PW-1:0] svc_parm_in = '0, prefix = '0;
    logic [TW-1:0] tod = '0, clk_cmp = '0, cpu_timer = '0;
    logic irq_valid, sa_we, sa_word;
    logic [15:0] irq_code;
    logic [AW-1:0] irq_cpu;
    logic [PW-1:0] irq_parm, sa_data;
    logic [SAW-1:0] sa_addr;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ext_irq_selector u_dut (.*);

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic quiet(string tag);
        chk({tag, " irq_valid"}, 64'(irq_valid), 0);
        chk({tag, " sa_we"}, 64'(sa_we), 0);
    endtask

    // one evaluation with full check of pulse and strobes
    task automatic do_eval(string tag, bit fires, logic [15:0] code, logic [15:0] cpu,
                           logic [31:0] parm, logic [15:0] save, bit with_key = 0);
        @(negedge clk); eval_req = 1; raise_key = with_key;
        @(negedge clk); eval_req = 0; raise_key = 0;
        if (!fires) begin quiet(tag); return; end
        chk({tag, " valid"}, 64'(irq_valid), 1);
        chk({tag, " code"}, 64'(irq_code), 64'(code));
        chk({tag, " cpu"}, 64'(irq_cpu), 64'(cpu));
        chk({tag, " parm"}, 64'(irq_parm), 64'(parm));
        @(negedge clk);
        if (code == 16'h2401) begin
            chk({tag, " R7 parm strobe"}, {sa_we, sa_word, 20'h0, sa_addr, sa_data},
                {1'b1, 1'b1, 20'h0, 12'h080, parm});
            @(negedge clk);
        end
        chk({tag, " R5 cpu strobe"}, {sa_we, sa_word, 20'h0, sa_addr, sa_data},
            {1'b1, 1'b0, 20'h0, 12'h084, 16'h0, save});
        @(negedge clk);
        chk({tag, " R8 code strobe"}, {sa_we, sa_word, 20'h0, sa_addr, sa_data},
            {1'b1, 1'b0, 20'h0, 12'h086, 16'h0, code});
        @(negedge clk);
        quiet({tag, " R9 end"});
    endtask

    task automatic t_reset();
        quiet("R12 reset");
        do_eval("R12 empty eval", 0, 0, 0, 0, 0);
    endtask

    task automatic t_priority();
        @(negedge clk);
        raise_key = 1; raise_malf = 1; malf_from = 8'b0010_0100; raise_emer = 1;
        emer_from = 8'b0000_1000; raise_xcall = 1; xcall_from = 16'h0007;
        raise_itmr = 1; raise_svc = 1; svc_parm_in = 32'h0000_1234;
        @(negedge clk);
        {raise_key, raise_malf, raise_emer, raise_xcall, raise_itmr, raise_svc} = '0;
        malf_from = '0; emer_from = '0;
        do_eval("R1 key",   1, 16'h0040, 0, 0, 0);
        do_eval("R3 malf2", 1, 16'h1200, 2, 0, 0);
        do_eval("R3 malf5", 1, 16'h1200, 5, 0, 0);
        do_eval("R5 emer3", 1, 16'h1201, 3, 0, 3);
        do_eval("R5 xcall", 1, 16'h1202, 7, 0, 7);
        do_eval("R1 itmr",  1, 16'h0080, 0, 0, 0);
        do_eval("R7 svc",   1, 16'h2401, 0, 32'h0000_1234, 0);
        do_eval("R1 none",  0, 0, 0, 0, 0);
    endtask

    task automatic t_timers();
        tod = 64'd100; clk_cmp = 64'd100;
        do_eval("R6 equal", 0, 0, 0, 0, 0);
        tod = 64'd101;
        do_eval("R6 clkc", 1, 16'h1004, 0, 0, 0);
        do_eval("R6 clkc again", 1, 16'h1004, 0, 0, 0);
        tod = 0; cpu_timer = 64'h8000_0000_0000_0000;
        do_eval("R6 timer", 1, 16'h1005, 0, 0, 0);
        cpu_timer = 64'd5;
        do_eval("R6 timer pos", 0, 0, 0, 0, 0);
    endtask

    task automatic t_mask();
        @(negedge clk);
        raise_malf = 1; malf_from = 8'b0000_0010; raise_emer = 1; emer_from = 8'b0001_0000;
        @(negedge clk);
        raise_malf = 0; raise_emer = 0; malf_from = '0; emer_from = '0;
        class_mask = 8'hFD;
        do_eval("R2 masked malf", 1, 16'h1201, 4, 0, 4);
        do_eval("R2 only masked", 0, 0, 0, 0, 0);
        class_mask = 8'hFF;
        do_eval("R2 kept malf", 1, 16'h1200, 1, 0, 0);
        do_eval("R2 none", 0, 0, 0, 0, 0);
    endtask

    task automatic t_empty();
        @(negedge clk);
        raise_malf = 1; malf_from = '0; raise_itmr = 1;
        @(negedge clk);
        raise_malf = 0; raise_itmr = 0;
        do_eval("R4 empty flag", 0, 0, 0, 0, 0);
        do_eval("R4 next itmr", 1, 16'h0080, 0, 0, 0);
        do_eval("R4 none", 0, 0, 0, 0, 0);
    endtask

    task automatic t_svc_reloc();
        prefix = 32'h0002_3000;
        @(negedge clk); raise_svc = 1; svc_parm_in = 32'h0000_0101;
        @(negedge clk); raise_svc = 0;
        do_eval("R7 page0", 1, 16'h2401, 0, 32'h0002_3101, 0);
        @(negedge clk); raise_svc = 1; svc_parm_in = 32'h0002_3041;
        @(negedge clk); raise_svc = 0;
        do_eval("R7 pfxpage", 1, 16'h2401, 0, 32'h0000_0041, 0);
        @(negedge clk); raise_svc = 1; svc_parm_in = 32'h0000_0100;
        @(negedge clk); raise_svc = 0;
        do_eval("R7 noflag", 1, 16'h2401, 0, 32'h0000_0100, 0);
        do_eval("R7 cleared", 0, 0, 0, 0, 0);
    endtask

    task automatic t_disabled();
        @(negedge clk); raise_key = 1;
        @(negedge clk); raise_key = 0; ext_enable = 0;
        do_eval("R10 disabled", 0, 0, 0, 0, 0);
        ext_enable = 1;
        do_eval("R10 key kept", 1, 16'h0040, 0, 0, 0);
    endtask

    task automatic t_same_edge();
        @(negedge clk); raise_key = 1;
        @(negedge clk); raise_key = 0;
        do_eval("R11 serve+raise", 1, 16'h0040, 0, 0, 0, 1);
        do_eval("R11 again", 1, 16'h0040, 0, 0, 0);
        do_eval("R11 none", 0, 0, 0, 0, 0);
    endtask

    task automatic t_busy();
        @(negedge clk); raise_key = 1; raise_itmr = 1;
        @(negedge clk); raise_key = 0; raise_itmr = 0; eval_req = 1;
        @(negedge clk); eval_req = 1;
        chk("R10 busy post", 64'(irq_code), 64'h0040);
        @(negedge clk); eval_req = 0;
        chk("R10 busy cpu strobe", {sa_we, 20'h0, sa_addr}, {1'b1, 20'h0, 12'h084});
        @(negedge clk);
        chk("R10 busy code strobe", 64'(sa_addr), 64'h086);
        @(negedge clk);
        quiet("R10 busy idle");
        do_eval("R10 itmr kept", 1, 16'h0080, 0, 0, 0);
    endtask

    initial begin
        #3000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_priority();
        t_timers();
        t_mask();
        t_empty();
        t_svc_reloc();
        t_disabled();
        t_same_edge();
        t_busy();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule